// File: doc/BRIEF.md
# Inter-Processor Doorbell Unit

This unit lets software on any processor core raise doorbell interrupts on one or more cores, including itself. It sits on a simple register bus beside the interrupt distributor. One register is shared by all cores and is written to ring a bell. Each core also has its own cause register and its own enable (mask) register. A core-index input picks which core's pair of registers a bus access reaches.

A ring command is a single write. It names one doorbell number and a bitmap of target cores, and it latches that doorbell's bit into the cause register of every targeted core. Each core receives one summary line, asserted while any cause bit of that core is also enabled in its mask. That line is meant to drive source ID 0 of the distributor for that core.

A core acknowledges its doorbells by writing its cause register. Every bit written as 0 is cleared and every bit written as 1 is kept. So writing 0 drops everything, and writing the inverse of 0xFF drops only bells 7:0.

Top module: `dbell_unit`

## Requirements
- R1: On a synchronous active-high reset, every cause register and every mask register becomes 0, and every summary line is low.
- R2: A write to offset 0x04 (ring register) sets cause bit `wdata[4:0]` in the cause register of every core `i` for which `wdata[8+i]` is 1. The new bit is readable from the next cycle on. The core-index input plays no part in a ring write.
- R3: Ring-register bits 7:5 have no effect. Target bits at positions 8+NCPU and above have no effect: a ring write whose only target bits lie there changes no cause register.
- R4: A write to offset 0x08 updates only the cause register of the core named by the core-index input. It clears each bit written as 0 and leaves each bit written as 1 unchanged. Writing 0 clears the whole register.
- R5: A write to offset 0x0C stores the full written word into the mask register of the selected core only.
- R6: Summary line `i` is the OR over all bits of (cause AND mask) of core `i`. It follows any register change from the cycle after the write.
- R7: Reads at offset 0x08 and 0x0C return the selected core's cause and mask registers, combinationally. Reads of any other offset return 0. Writes to offsets other than 0x04, 0x08 and 0x0C change nothing.
- R8: Ringing a bell whose cause bit is already set leaves it set, and a ring write never clears any cause bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | AW (8) | Register byte offset |
| bus_wdata | input | DW (32) | Write data |
| bus_cpu | input | CPU_W (2) | Core whose private registers the access reaches |
| bus_rdata | output | DW (32) | Combinational read data for bus_addr / bus_cpu |
| bell_pending | output | NCPU (4) | Per-core doorbell summary line |

## Verification
The bench builds the unit with its defaults: four cores and 32 cause bits. This places the target bitmap at bits 11:8, so bit 12 and above act as targets for cores that do not exist, and the R3 ghost-target case can be driven. With 32 cause bits, bell 31 can be rung. That lets the bench check that clearing with the inverse of 0xFF keeps the upper bells. Different masks per core, including an empty mask and a single-bit mask, let the bench tell a set cause bit apart from a raised summary line.

// File: rtl/dbell_pkg.sv
package dbell_pkg;

    // Register byte offsets; software depends on these values.
    localparam logic [7:0] OFS_RING  = 8'h04;
    localparam logic [7:0] OFS_CAUSE = 8'h08;
    localparam logic [7:0] OFS_MASK  = 8'h0C;

    // First bit of the target-core bitmap inside a ring write.
    localparam int TGT_LSB = 8;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_RING  = 2'd1,
        ACC_CAUSE = 2'd2,
        ACC_MASK  = 2'd3
    } acc_kind_e;

    // Classify an offset that has been widened to 16 bits.
    function automatic acc_kind_e classify(input logic [15:0] ofs);
        if (ofs == {8'h00, OFS_RING})
            return ACC_RING;
        else if (ofs == {8'h00, OFS_CAUSE})
            return ACC_CAUSE;
        else if (ofs == {8'h00, OFS_MASK})
            return ACC_MASK;
        else
            return ACC_NONE;
    endfunction

    // Core index width that stays at least one bit.
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/dbell_decode.sv
module dbell_decode
    import dbell_pkg::*;
#(
    parameter int NCPU   = 4,
    parameter int NBELL  = 32,
    parameter int AW     = 8,
    parameter int CPU_W  = 2,
    localparam int BELL_W = idx_width(NBELL)
) (
    input  logic                        wr,
    input  logic [AW-1:0]               addr,
    input  logic [CPU_W-1:0]            cpu,
    input  logic [BELL_W-1:0]           bell,
    input  logic [NCPU-1:0]             targets,
    output logic [NCPU-1:0][NBELL-1:0]  set_vec,
    output logic [NCPU-1:0]             cause_we,
    output logic [NCPU-1:0]             mask_we
);

    acc_kind_e kind;
    logic [NBELL-1:0] bell_onehot;

    assign kind        = classify(16'(addr));
    assign bell_onehot = NBELL'(1) << bell;

    for (genvar i = 0; i < NCPU; i++) begin : g_core
        logic hit;
        assign hit         = (int'(cpu) == i);
        assign set_vec[i]  = (wr && kind == ACC_RING && targets[i]) ? bell_onehot : '0;
        assign cause_we[i] = wr && kind == ACC_CAUSE && hit;
        assign mask_we[i]  = wr && kind == ACC_MASK && hit;
    end

endmodule

// File: rtl/dbell_cpu_bank.sv
module dbell_cpu_bank #(
    parameter int NBELL = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NBELL-1:0] set_vec,
    input  logic             cause_we,
    input  logic             mask_we,
    input  logic [NBELL-1:0] wdata,
    output logic [NBELL-1:0] cause_q,
    output logic [NBELL-1:0] mask_q,
    output logic             pending
);

    logic [NBELL-1:0] keep;

    // A cause write keeps only bits written as 1; a ring set is ORed last so it wins.
    assign keep = cause_we ? wdata : '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= '0;
            mask_q  <= '0;
        end else begin
            cause_q <= (cause_q & keep) | set_vec;
            if (mask_we)
                mask_q <= wdata;
        end
    end

    assign pending = |(cause_q & mask_q);

endmodule

// File: rtl/dbell_unit.sv
module dbell_unit
    import dbell_pkg::*;
#(
    parameter int NCPU  = 4,
    parameter int NBELL = 32,
    parameter int AW    = 8,
    parameter int DW    = 32,
    localparam int CPU_W  = idx_width(NCPU),
    localparam int BELL_W = idx_width(NBELL)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    input  logic [CPU_W-1:0] bus_cpu,
    output logic [DW-1:0]    bus_rdata,
    output logic [NCPU-1:0]  bell_pending
);

    logic [NCPU-1:0][NBELL-1:0] set_vec;
    logic [NCPU-1:0]            cause_we;
    logic [NCPU-1:0]            mask_we;
    logic [NCPU-1:0][NBELL-1:0] cause_all;
    logic [NCPU-1:0][NBELL-1:0] mask_all;
    acc_kind_e                  rd_kind;

    dbell_decode #(
        .NCPU  (NCPU),
        .NBELL (NBELL),
        .AW    (AW),
        .CPU_W (CPU_W)
    ) u_decode (
        .wr       (bus_wr),
        .addr     (bus_addr),
        .cpu      (bus_cpu),
        .bell     (bus_wdata[BELL_W-1:0]),
        .targets  (bus_wdata[TGT_LSB +: NCPU]),
        .set_vec  (set_vec),
        .cause_we (cause_we),
        .mask_we  (mask_we)
    );

    for (genvar i = 0; i < NCPU; i++) begin : g_bank
        dbell_cpu_bank #(
            .NBELL (NBELL)
        ) u_bank (
            .clk      (clk),
            .rst      (rst),
            .set_vec  (set_vec[i]),
            .cause_we (cause_we[i]),
            .mask_we  (mask_we[i]),
            .wdata    (bus_wdata[NBELL-1:0]),
            .cause_q  (cause_all[i]),
            .mask_q   (mask_all[i]),
            .pending  (bell_pending[i])
        );
    end

    assign rd_kind = classify(16'(bus_addr));

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NCPU; i++) begin
            if (int'(bus_cpu) == i) begin
                if (rd_kind == ACC_CAUSE)
                    bus_rdata = DW'(cause_all[i]);
                else if (rd_kind == ACC_MASK)
                    bus_rdata = DW'(mask_all[i]);
            end
        end
    end

endmodule

// File: rtl/dbell_sva.sv
module dbell_sva
    import dbell_pkg::*;
#(
    parameter int NCPU  = 4,
    parameter int AW    = 8,
    parameter int DW    = 32,
    parameter int CPU_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_wr,
    input logic [AW-1:0]    bus_addr,
    input logic [DW-1:0]    bus_wdata,
    input logic [CPU_W-1:0] bus_cpu,
    input logic [NCPU-1:0]  bell_pending
);

    acc_kind_e kind;
    assign kind = classify(16'(bus_addr));

    // R1: reset leaves every summary line low
    a_r1_reset_quiet: assert property (@(posedge clk) rst |=> bell_pending == '0);

    // R8: a ring write never lowers a summary line
    a_r8_ring_no_drop: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && kind == ACC_RING) |=> ((bell_pending & $past(bell_pending)) == $past(bell_pending)));

    // R3: ring with no existing target changes nothing
    a_r3_ghost_targets: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && kind == ACC_RING && bus_wdata[TGT_LSB +: NCPU] == '0) |=> $stable(bell_pending));

    // R7: writes to unmapped offsets and idle cycles change nothing
    a_r7_unmapped_stable: assert property (@(posedge clk) disable iff (rst)
        (!bus_wr || kind == ACC_NONE) |=> $stable(bell_pending));

    for (genvar i = 0; i < NCPU; i++) begin : g_chk
        // R4: clearing the whole cause register drops the line
        a_r4_clear_all: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && kind == ACC_CAUSE && int'(bus_cpu) == i && bus_wdata == '0) |=> !bell_pending[i]);
        // R5: an empty mask silences the line
        a_r5_mask_zero: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && kind == ACC_MASK && int'(bus_cpu) == i && bus_wdata == '0) |=> !bell_pending[i]);
        // R4: a cause or mask write aimed at another core leaves this line alone
        a_r4_other_core: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && (kind == ACC_CAUSE || kind == ACC_MASK) && int'(bus_cpu) != i) |=> $stable(bell_pending[i]));
    end

endmodule

bind dbell_unit dbell_sva #(
    .NCPU  (NCPU),
    .AW    (AW),
    .DW    (DW),
    .CPU_W (CPU_W)
) u_sva (
    .clk          (clk),
    .rst          (rst),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_cpu      (bus_cpu),
    .bell_pending (bell_pending)
);

// File: tb/dbell_unit_tb.sv
module dbell_unit_tb;

    localparam int NCPU = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [1:0]  bus_cpu = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  bell_pending;

    int checks = 0;
    int failures = 0;
    bit live = 1'b0;

    logic [31:0] m_cause [NCPU];
    logic [31:0] m_mask  [NCPU];

    always #5 clk = ~clk;

    dbell_unit u_dut (
        .clk          (clk),
        .rst          (rst),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_cpu      (bus_cpu),
        .bus_rdata    (bus_rdata),
        .bell_pending (bell_pending)
    );

    function automatic logic [3:0] model_pending();
        logic [3:0] p;
        for (int i = 0; i < NCPU; i++) p[i] = |(m_cause[i] & m_mask[i]);
        return p;
    endfunction

    task automatic model_write(input int cpu, input logic [7:0] a, input logic [31:0] d);
        if (a == 8'h04) begin
            for (int i = 0; i < NCPU; i++)
                if (d[8+i]) m_cause[i] = m_cause[i] | (32'd1 << d[4:0]);
        end else if (a == 8'h08) begin
            m_cause[cpu] = m_cause[cpu] & d;
        end else if (a == 8'h0C) begin
            m_mask[cpu] = d;
        end
    endtask

    // R6: summary lines compared with the model on every clock
    always @(negedge clk) begin
        if (live) begin
            checks++;
            if (bell_pending !== model_pending()) begin
                failures++;
                $display("FAIL R6 pending per clock: actual=%b expected=%b", bell_pending, model_pending());
            end
        end
    end

    task automatic wr(input int cpu, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_cpu = 2'(cpu); bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        model_write(cpu, a, d);
        bus_wr = 1'b0;
    endtask

    task automatic rd_check(input int cpu, input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_cpu = 2'(cpu); bus_addr = a;
        #1;
        checks++;
        if (bus_rdata !== exp) begin
            failures++;
            $display("FAIL %s cpu%0d ofs=%h: actual=%h expected=%h", tag, cpu, a, bus_rdata, exp);
        end
    endtask

    task automatic pend_check(input logic [3:0] exp, input string tag);
        @(negedge clk);
        checks++;
        if (bell_pending !== exp) begin
            failures++;
            $display("FAIL %s pending: actual=%b expected=%b", tag, bell_pending, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < NCPU; i++) begin m_cause[i] = '0; m_mask[i] = '0; end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        live = 1'b1;

        // R1: reset state
        pend_check(4'b0000, "R1");
        for (int i = 0; i < NCPU; i++) begin
            rd_check(i, 8'h08, 32'h0, "R1 cause");
            rd_check(i, 8'h0C, 32'h0, "R1 mask");
        end

        // R5: per-core masks
        wr(0, 8'h0C, 32'h0000_00FF);
        wr(1, 8'h0C, 32'hFFFF_FFFF);
        wr(2, 8'h0C, 32'h0000_0000);
        wr(3, 8'h0C, 32'h0000_0100);
        rd_check(0, 8'h0C, 32'h0000_00FF, "R5 mask0");
        rd_check(3, 8'h0C, 32'h0000_0100, "R5 mask3");
        rd_check(1, 8'h0C, 32'hFFFF_FFFF, "R5 mask1");

        // R2: bell 3 to cores 0 and 1, issued with bus_cpu = 3
        wr(3, 8'h04, (32'b0011 << 8) | 32'd3);
        rd_check(0, 8'h08, 32'h0000_0008, "R2 cause0");
        rd_check(1, 8'h08, 32'h0000_0008, "R2 cause1");
        rd_check(2, 8'h08, 32'h0, "R2 cause2 untouched");
        pend_check(4'b0011, "R6");

        // R3: bits 7:5 set, bell 8 to cores 2 and 3
        wr(0, 8'h04, (32'b1100 << 8) | (32'd7 << 5) | 32'd8);
        rd_check(2, 8'h08, 32'h0000_0100, "R3 cause2");
        rd_check(3, 8'h08, 32'h0000_0100, "R3 cause3");
        pend_check(4'b1011, "R6 masked core2");

        // R3: only nonexistent targets
        wr(0, 8'h04, (32'd1 << 12) | (32'd1 << 20) | 32'd1);
        for (int i = 0; i < NCPU; i++)
            rd_check(i, 8'h08, m_cause[i], "R3 ghost target");
        rd_check(0, 8'h08, 32'h0000_0008, "R3 ghost cause0");

        // R8: ring the same bell again
        wr(0, 8'h04, (32'b0001 << 8) | 32'd3);
        rd_check(0, 8'h08, 32'h0000_0008, "R8 re-ring");

        // R4: keep upper bell on core 1 while clearing bits 7:0
        wr(0, 8'h04, (32'b0010 << 8) | 32'd31);
        rd_check(1, 8'h08, 32'h8000_0008, "R2 bell31");
        wr(1, 8'h08, ~32'h0000_00FF);
        rd_check(1, 8'h08, 32'h8000_0000, "R4 partial clear");
        pend_check(4'b1011, "R6 after partial");

        // R4: clear all on core 0, core 3 untouched
        wr(0, 8'h08, 32'h0);
        rd_check(0, 8'h08, 32'h0, "R4 clear all");
        rd_check(3, 8'h08, 32'h0000_0100, "R4 other core kept");
        pend_check(4'b1010, "R6 after clear");

        // R7: unmapped and ring-register reads, unmapped writes
        rd_check(1, 8'h04, 32'h0, "R7 ring read");
        rd_check(1, 8'h10, 32'h0, "R7 unmapped read");
        wr(1, 8'h10, 32'h0);
        wr(3, 8'h4C, 32'h0);
        rd_check(1, 8'h08, 32'h8000_0000, "R7 unmapped write cause1");
        rd_check(3, 8'h08, 32'h0000_0100, "R7 unmapped write cause3");
        rd_check(3, 8'h0C, 32'h0000_0100, "R7 unmapped write mask3");

        // R5: dropping core 3 mask hides its line
        wr(3, 8'h0C, 32'h0);
        pend_check(4'b0010, "R5 mask off");

        // R1: reset again clears everything
        @(negedge clk); rst = 1'b1; live = 1'b0;
        @(posedge clk); #1 rst = 1'b0;
        for (int i = 0; i < NCPU; i++) begin m_cause[i] = '0; m_mask[i] = '0; end
        live = 1'b1;
        pend_check(4'b0000, "R1 second reset");
        rd_check(1, 8'h08, 32'h0, "R1 second reset cause1");

        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule